// File: doc/BRIEF.md
# Packet Slot Allocator

This block keeps track of which slots in a shared packet memory are in use. The memory is split into a parameterised number of equal slots, four slots of 2 KB by default. A host drives one command at a time through a small command port: take a transmit slot, hand a slot to the transmit queue, return a named slot, drop the oldest received packet, or clear all state. Allocation runs in the background. Its outcome is latched into a result (packet number plus a failure flag), and a sticky interrupt bit that the host acknowledges marks it done. A busy flag stays high while a command is being worked off, and commands that arrive during busy are dropped.

The receive side claims slots on its own through a one-cycle strobe. Each claimed slot number is appended to a receive queue, and the host sees the oldest entry and an empty flag. A transmit queue holds the packet numbers the host has enqueued. A test strobe pops the head of that queue. The amount of free memory is reported in 2 KB units.

Top module: `pkt_slot_alloc`

## Requirements
- R1: After reset, every slot is free, `free_units` reads the full memory size, both queues are empty, and `busy`, `alloc_int` and `alloc_fail` are 0.
- R2: An allocate command (`cmd_op` = 1) taken while not busy grants the lowest-numbered free slot. From the next cycle, `alloc_pnum` holds that number, `alloc_fail` is 0, `alloc_int` is 1, and the slot counts as used.
- R3: An allocate command whose page code (`cmd_pages`, number of 256-byte pages minus one) exceeds 7, or that finds no free slot, sets `alloc_fail` to 1, `alloc_pnum` to 0 and `alloc_int` to 1, and takes no slot.
- R4: `alloc_int` stays set until a pulse on `irq_ack` clears it. If an allocation completes in the same cycle as the acknowledge, the bit stays set.
- R5: Every accepted command raises `busy` from the next cycle for exactly BUSY_CYCLES cycles. A command presented while `busy` is high is ignored.
- R6: A free command (`cmd_op` = 4) returns the slot named in the packet-number register (written through `pnum_wr`) to the free pool. Freeing a slot that is already free changes nothing.
- R7: An enqueue command (`cmd_op` = 5) appends the packet-number register to the transmit queue. `tx_pop` removes the head, entries leave in the order they arrived, and an enqueue into a full queue is dropped.
- R8: A `rx_claim` strobe takes the lowest free slot not granted to a host allocation in the same cycle and appends it to the receive queue, with `rx_head` showing the oldest entry. The strobe has no effect when no slot is free or the receive queue is full.
- R9: A release command (`cmd_op` = 3) removes the head of the receive queue and frees its slot. On an empty queue it has no effect on the slots.
- R10: A reset command (`cmd_op` = 2) frees every slot, empties both queues and clears `alloc_int`.
- R11: `free_units` equals the number of free slots times SLOT_BYTES/2048.
- R12: Command codes 0, 6 and 7 change no state and do not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (1 alloc, 2 reset, 3 release, 4 free, 5 enqueue) |
| cmd_pages | input | PAGE_W | Page code of an allocate command |
| pnum_wr | input | 1 | Write strobe of the packet-number register |
| pnum_wdata | input | PNUM_W | Value written to the packet-number register |
| irq_ack | input | 1 | Clears the allocation interrupt bit |
| rx_claim | input | 1 | Receive side claims a slot |
| tx_pop | input | 1 | Test strobe that pops the transmit queue |
| busy | output | 1 | A command is being worked off |
| alloc_int | output | 1 | Sticky allocation-done bit |
| alloc_fail | output | 1 | Last allocation failed |
| alloc_pnum | output | PNUM_W | Packet number of the last allocation |
| rx_empty | output | 1 | Receive queue is empty |
| rx_head | output | PNUM_W | Oldest receive packet number |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_head | output | PNUM_W | Oldest transmit packet number |
| free_units | output | FREE_W | Free memory in 2 KB units |

## Verification
The bench builds the block with four slots, a three-cycle busy window and a receive queue only two entries deep. A queue shallower than the slot count lets a claim hit a full queue while slots are still free. The longer busy window leaves room to present a second command inside it and see it dropped. A transmit queue of four lets five enqueues show the overflow drop, and a same-cycle host allocation and receive claim shows how the two grants are split between slots.

// File: rtl/pkt_slot_alloc_pkg.sv
package pkt_slot_alloc_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_ALLOC   = 3'd1,
      OP_RESET   = 3'd2,
      OP_RELEASE = 3'd3,
      OP_FREE    = 3'd4,
      OP_ENQUEUE = 3'd5
   } slot_op_e;

   localparam int UNIT_BYTES = 2048;
endpackage

// File: rtl/pa_fifo.sv
module pa_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("pa_fifo: DEPTH must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else if (clr) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= step(wr_ptr);
         if (do_pop)  rd_ptr <= step(rd_ptr);
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr] <= push_data;
   end

   // R7 / R8: a push into a full queue is dropped
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> $stable(cnt));

   // R9: a pop of a non-empty queue removes exactly one entry
   assert_pop_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push && !clr) |=> ((cnt + CW'(1)) == $past(cnt)));
endmodule

// File: rtl/pa_slot_map.sv
module pa_slot_map #(
   parameter int NUM_SLOTS = 4,
   parameter int IDX_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 take_a,
   input  logic                 take_b,
   input  logic                 rel_a_en,
   input  logic [IDX_W-1:0]     rel_a_idx,
   input  logic                 rel_b_en,
   input  logic [IDX_W-1:0]     rel_b_idx,
   output logic [NUM_SLOTS-1:0] free_map,
   output logic                 a_ok,
   output logic [IDX_W-1:0]     a_idx,
   output logic                 b_ok,
   output logic [IDX_W-1:0]     b_idx
);
   if ((1 << IDX_W) < NUM_SLOTS) begin : g_bad_idx
      $error("pa_slot_map: IDX_W too narrow for NUM_SLOTS");
   end

   logic [NUM_SLOTS-1:0] a_mask, b_avail, take_mask, rel_mask;

   // lowest free slot for the host grant
   always_comb begin
      a_ok  = 1'b0;
      a_idx = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (free_map[i]) begin
            a_ok  = 1'b1;
            a_idx = IDX_W'(i);
         end
      end
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_amask
      assign a_mask[g] = take_a && a_ok && (a_idx == IDX_W'(g));
   end

   assign b_avail = free_map & ~a_mask;

   // lowest slot left over for the receive claim
   always_comb begin
      b_ok  = 1'b0;
      b_idx = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (b_avail[i]) begin
            b_ok  = 1'b1;
            b_idx = IDX_W'(i);
         end
      end
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_masks
      assign take_mask[g] = a_mask[g] || (take_b && b_ok && (b_idx == IDX_W'(g)));
      assign rel_mask[g]  = (rel_a_en && (rel_a_idx == IDX_W'(g))) ||
                            (rel_b_en && (rel_b_idx == IDX_W'(g)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   free_map <= '1;
      else if (clr) free_map <= '1;
      else          free_map <= (free_map & ~take_mask) | rel_mask;
   end

   // R10: a clear frees all slots
   assert_clear_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (&free_map));

   // R2: the granted slot is no longer free
   assert_grant_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take_a && a_ok && !clr && !rel_a_en && !rel_b_en) |=> !free_map[$past(a_idx)]);

   // R8: host grant and receive claim never share a slot
   assert_split_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_a && a_ok && take_b && b_ok) |-> (a_idx != b_idx));
endmodule

// File: rtl/pa_busy_timer.sv
module pa_busy_timer #(
   parameter int CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("pa_busy_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CW'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);

   // R5: an accepted command raises busy in the next cycle
   assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R12: without a start, an idle timer stays idle
   assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy);
endmodule

// File: rtl/pkt_slot_alloc.sv
module pkt_slot_alloc
   import pkt_slot_alloc_pkg::*;
#(
   parameter int NUM_SLOTS   = 4,
   parameter int SLOT_BYTES  = 2048,
   parameter int PAGE_BYTES  = 256,
   parameter int PAGE_W      = 4,
   parameter int PNUM_W      = 6,
   parameter int FREE_W      = 8,
   parameter int BUSY_CYCLES = 2,
   parameter int RX_DEPTH    = 4,
   parameter int TX_DEPTH    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [PAGE_W-1:0] cmd_pages,
   input  logic              pnum_wr,
   input  logic [PNUM_W-1:0] pnum_wdata,
   input  logic              irq_ack,
   input  logic              rx_claim,
   input  logic              tx_pop,
   output logic              busy,
   output logic              alloc_int,
   output logic              alloc_fail,
   output logic [PNUM_W-1:0] alloc_pnum,
   output logic              rx_empty,
   output logic [PNUM_W-1:0] rx_head,
   output logic              tx_empty,
   output logic [PNUM_W-1:0] tx_head,
   output logic [FREE_W-1:0] free_units
);
   localparam int IDX_W          = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
   localparam int MAX_PAGE_CODE  = SLOT_BYTES / PAGE_BYTES - 1;
   localparam int UNITS_PER_SLOT = SLOT_BYTES / UNIT_BYTES;
   localparam int CNT_W          = $clog2(NUM_SLOTS + 1);
   localparam int FULL_UNITS     = NUM_SLOTS * UNITS_PER_SLOT;

   if (SLOT_BYTES % UNIT_BYTES != 0) begin : g_bad_slot
      $error("pkt_slot_alloc: SLOT_BYTES must be a multiple of 2048");
   end
   if (PNUM_W < IDX_W) begin : g_bad_pnum
      $error("pkt_slot_alloc: PNUM_W narrower than slot index");
   end
   if (FULL_UNITS >= (1 << FREE_W)) begin : g_bad_free
      $error("pkt_slot_alloc: FREE_W cannot hold the full memory size");
   end

   slot_op_e             op;
   logic                 accept, is_alloc, is_reset, is_rel, is_free, is_enq;
   logic                 pages_ok, take_a, rx_take;
   logic [PNUM_W-1:0]    pnum_reg;
   logic [NUM_SLOTS-1:0] free_map;
   logic                 a_ok, b_ok, rx_full, tx_full;
   logic [IDX_W-1:0]     a_idx, b_idx;
   logic [CNT_W-1:0]     nfree;

   assign op       = slot_op_e'(cmd_op);
   assign accept   = cmd_valid && !busy &&
                     (op == OP_ALLOC || op == OP_RESET || op == OP_RELEASE ||
                      op == OP_FREE  || op == OP_ENQUEUE);
   assign is_alloc = accept && (op == OP_ALLOC);
   assign is_reset = accept && (op == OP_RESET);
   assign is_rel   = accept && (op == OP_RELEASE);
   assign is_free  = accept && (op == OP_FREE);
   assign is_enq   = accept && (op == OP_ENQUEUE);
   assign pages_ok = (cmd_pages <= PAGE_W'(MAX_PAGE_CODE));
   assign take_a   = is_alloc && pages_ok;
   assign rx_take  = rx_claim && !is_reset && !rx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pnum_reg <= '0;
      else if (pnum_wr) pnum_reg <= pnum_wdata;
   end

   pa_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .busy  (busy)
   );

   pa_slot_map #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (is_reset),
      .take_a    (take_a),
      .take_b    (rx_take),
      .rel_a_en  (is_rel && !rx_empty),
      .rel_a_idx (rx_head[IDX_W-1:0]),
      .rel_b_en  (is_free && (pnum_reg < PNUM_W'(NUM_SLOTS))),
      .rel_b_idx (pnum_reg[IDX_W-1:0]),
      .free_map  (free_map),
      .a_ok      (a_ok),
      .a_idx     (a_idx),
      .b_ok      (b_ok),
      .b_idx     (b_idx)
   );

   pa_fifo #(.DEPTH(RX_DEPTH), .W(PNUM_W)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (is_reset),
      .push      (rx_take && b_ok),
      .push_data (PNUM_W'(b_idx)),
      .pop       (is_rel),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full)
   );

   pa_fifo #(.DEPTH(TX_DEPTH), .W(PNUM_W)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (is_reset),
      .push      (is_enq),
      .push_data (pnum_reg),
      .pop       (tx_pop),
      .head      (tx_head),
      .empty     (tx_empty),
      .full      (tx_full)
   );

   // allocation result and sticky interrupt bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alloc_pnum <= '0;
         alloc_fail <= 1'b0;
         alloc_int  <= 1'b0;
      end else begin
         if (is_alloc) begin
            alloc_pnum <= (take_a && a_ok) ? PNUM_W'(a_idx) : '0;
            alloc_fail <= !(take_a && a_ok);
         end
         if (is_reset)      alloc_int <= 1'b0;
         else if (is_alloc) alloc_int <= 1'b1;
         else if (irq_ack)  alloc_int <= 1'b0;
      end
   end

   always_comb begin
      nfree = '0;
      for (int i = 0; i < NUM_SLOTS; i++) nfree = nfree + CNT_W'(free_map[i]);
   end

   if (UNITS_PER_SLOT == 1) begin : g_units_direct
      assign free_units = FREE_W'(nfree);
   end else begin : g_units_scaled
      assign free_units = FREE_W'(nfree) * FREE_W'(UNITS_PER_SLOT);
   end

   // R3: an illegal page code fails the allocation
   assert_bad_pages_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_alloc && !pages_ok) |=> (alloc_fail && alloc_int && (alloc_pnum == '0)));

   // R4: an acknowledge with no competing event clears the bit
   assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !is_alloc) |=> !alloc_int);

   // R11: after a reset command the whole memory is reported free
   assert_reset_full_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
      is_reset |=> (free_units == FREE_W'(FULL_UNITS)));

   // R7: an enqueue into a non-full queue leaves it non-empty
   assert_enq_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_enq && !tx_full) |=> !tx_empty);
endmodule

// File: tb/pkt_slot_alloc_tb.sv
module pkt_slot_alloc_tb;
   localparam int NS = 4;
   localparam int BC = 3;
   localparam int RXD = 2;
   localparam int TXD = 4;
   localparam int PW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [3:0] cmd_pages = '0;
   logic pnum_wr = 1'b0;
   logic [PW-1:0] pnum_wdata = '0;
   logic irq_ack = 1'b0;
   logic rx_claim = 1'b0;
   logic tx_pop = 1'b0;
   logic busy, alloc_int, alloc_fail, rx_empty, tx_empty;
   logic [PW-1:0] alloc_pnum, rx_head, tx_head;
   logic [7:0] free_units;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit prev_int = 1'b0;
   logic [NS-1:0] mfree = '1;
   logic [8:0] exp_alloc [$];
   int exp_tx [$];

   always #2 clk = ~clk;

   pkt_slot_alloc #(
      .NUM_SLOTS(NS), .SLOT_BYTES(2048), .PAGE_BYTES(256), .PAGE_W(4),
      .PNUM_W(PW), .FREE_W(8), .BUSY_CYCLES(BC), .RX_DEPTH(RXD), .TX_DEPTH(TXD)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_pages(cmd_pages), .pnum_wr(pnum_wr), .pnum_wdata(pnum_wdata),
      .irq_ack(irq_ack), .rx_claim(rx_claim), .tx_pop(tx_pop), .busy(busy),
      .alloc_int(alloc_int), .alloc_fail(alloc_fail), .alloc_pnum(alloc_pnum),
      .rx_empty(rx_empty), .rx_head(rx_head), .tx_empty(tx_empty),
      .tx_head(tx_head), .free_units(free_units)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int lowest(input logic [NS-1:0] m);
      for (int i = 0; i < NS; i++) if (m[i]) return i;
      return -1;
   endfunction

   // monitor: compares each completed allocation with the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (alloc_int && !prev_int) begin
            if (exp_alloc.size() == 0) begin
               checks++;
               errors++;
               $display("FAIL R2 unexpected completion actual=1 expected=0");
            end else begin
               logic [8:0] e;
               e = exp_alloc.pop_front();
               chk(e[8] ? "R3 alloc_fail" : "R2 alloc_fail", alloc_fail, e[8]);
               chk(e[8] ? "R3 alloc_pnum" : "R2 alloc_pnum", alloc_pnum, e[7:0]);
            end
         end
         prev_int = alloc_int;
      end
   end

   task automatic issue(input logic [2:0] op, input logic [3:0] pages);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_pages = pages;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = '0; cmd_pages = '0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic set_pnum(input int v);
      @(negedge clk); pnum_wr = 1'b1; pnum_wdata = PW'(v);
      @(negedge clk); pnum_wr = 1'b0;
   endtask

   task automatic claim();
      @(negedge clk); rx_claim = 1'b1;
      @(negedge clk); rx_claim = 1'b0;
   endtask

   // driver: predicts the allocation outcome and queues it
   task automatic do_alloc(input logic [3:0] pages, input bit do_ack);
      int s;
      s = lowest(mfree);
      if (pages > 7 || s < 0) exp_alloc.push_back({1'b1, 8'd0});
      else begin
         exp_alloc.push_back({1'b0, 8'(s)});
         mfree[s] = 1'b0;
      end
      issue(3'd1, pages);
      wait_idle();
      if (do_ack) ack();
   endtask

   task automatic enqueue(input int v);
      set_pnum(v);
      if (exp_tx.size() < TXD) exp_tx.push_back(v);
      issue(3'd5, 4'd0);
      wait_idle();
   endtask

   task automatic pop_tx();
      @(negedge clk);
      chk("R7 tx_empty before pop", tx_empty, 0);
      chk("R7 tx_head order", tx_head, exp_tx.pop_front());
      tx_pop = 1'b1;
      @(negedge clk); tx_pop = 1'b0;
   endtask

   task automatic chk_free(input string req);
      chk(req, free_units, $countones(mfree));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 busy", busy, 0);
      chk("R1 alloc_int", alloc_int, 0);
      chk("R1 alloc_fail", alloc_fail, 0);
      chk("R1 rx_empty", rx_empty, 1);
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 free_units", free_units, 4);

      // R12: unused codes
      issue(3'd0, 4'd0); chk("R12 busy op0", busy, 0);
      issue(3'd6, 4'd0); chk("R12 busy op6", busy, 0);
      issue(3'd7, 4'd0); chk("R12 busy op7", busy, 0);
      chk("R12 free_units", free_units, 4);
      chk("R12 alloc_int", alloc_int, 0);

      // R2, R5: first allocation and busy window
      exp_alloc.push_back({1'b0, 8'd0});
      mfree[0] = 1'b0;
      issue(3'd1, 4'd0);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R5 busy length", n, BC);
      chk_free("R11 free after alloc");
      // R4: sticky until acknowledged
      repeat (5) @(negedge clk);
      chk("R4 alloc_int held", alloc_int, 1);
      ack();
      chk("R4 alloc_int cleared", alloc_int, 0);

      do_alloc(4'd7, 1'b1);
      do_alloc(4'd8, 1'b1);
      chk_free("R3 no slot taken on bad page code");

      // R5: second command inside the busy window is dropped
      exp_alloc.push_back({1'b0, 8'd2});
      mfree[2] = 1'b0;
      issue(3'd1, 4'd0);
      issue(3'd1, 4'd0);
      wait_idle();
      chk_free("R5 command during busy ignored");
      ack();

      // R8: receive claim
      claim(); mfree[3] = 1'b0;
      chk("R8 rx_empty", rx_empty, 0);
      chk("R8 rx_head", rx_head, 3);
      chk_free("R11 free after claim");
      do_alloc(4'd0, 1'b1);
      claim();
      chk_free("R8 claim with no free slot");

      // R9: release
      issue(3'd3, 4'd0); wait_idle(); mfree[3] = 1'b1;
      chk("R9 rx_empty after release", rx_empty, 1);
      chk_free("R9 slot freed by release");
      issue(3'd3, 4'd0); wait_idle();
      chk_free("R9 release on empty queue");

      // R6: free a named slot, then free it again
      set_pnum(1);
      issue(3'd4, 4'd0); wait_idle(); mfree[1] = 1'b1;
      chk_free("R6 free slot 1");
      issue(3'd4, 4'd0); wait_idle();
      chk_free("R6 double free no effect");

      // R8: fill receive queue, then claim into a full queue
      claim(); mfree[1] = 1'b0;
      claim(); mfree[3] = 1'b0;
      chk("R8 rx_head oldest", rx_head, 1);
      set_pnum(0);
      issue(3'd4, 4'd0); wait_idle(); mfree[0] = 1'b1;
      claim();
      chk_free("R8 claim into full queue ignored");
      issue(3'd3, 4'd0); wait_idle(); mfree[1] = 1'b1;
      chk("R9 rx_head after release", rx_head, 3);
      chk_free("R9 free after release");

      // R8: host allocation and claim in one cycle
      exp_alloc.push_back({1'b0, 8'd0});
      mfree[0] = 1'b0; mfree[1] = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_pages = 4'd0; rx_claim = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = '0; rx_claim = 1'b0;
      wait_idle(); ack();
      chk_free("R8 split grant free count");
      issue(3'd3, 4'd0); wait_idle(); mfree[3] = 1'b1;
      chk("R8 claim got next slot", rx_head, 1);

      // R7: transmit queue order and overflow
      enqueue(2); enqueue(0); enqueue(5); enqueue(1); enqueue(3);
      for (int k = 0; k < TXD; k++) pop_tx();
      @(negedge clk);
      chk("R7 overflow entry dropped", tx_empty, 1);

      // R10: reset command
      enqueue(2);
      do_alloc(4'd0, 1'b0);
      issue(3'd2, 4'd0); wait_idle();
      mfree = '1;
      exp_tx.delete();
      chk("R10 free_units", free_units, 4);
      chk("R10 rx_empty", rx_empty, 1);
      chk("R10 tx_empty", tx_empty, 1);
      chk("R10 alloc_int", alloc_int, 0);
      do_alloc(4'd3, 1'b1);
      chk_free("R11 free after reset and alloc");

      repeat (2) @(negedge clk);
      chk("R2 scoreboard drained", exp_alloc.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule